// File: doc/BRIEF.md
# Per-Line Update/Invalidate Write Policy Selector

This block sits beside a cache's coherence controller and decides, for each local write that has to tell other caches about itself, whether to send the new data along (update) or to tell the other caches to drop their copies (invalidate). It keeps one small signed history counter per cache line. A snooped read that hits a valid line counts as evidence that other cores read the line, so the counter goes up. A completed local write counts against sharing, so the counter goes down. A fill from main memory restarts the history at zero.

A two-bit mode input picks the policy at runtime:
- always invalidate;
- always update;
- counter threshold, compared against a programmable signed threshold;
- an owned-state rule that ignores the counter.

For a requested line index and that line's current coherence state, the block returns the decision combinationally in the same cycle. The coherence state machine and the bus stay outside the block.

Top module: `wpol_select`

## Requirements
- R1: After reset every line counter is 0.
- R2: A fill event (`fill_vld`) sets the counter of line `fill_idx` to 0 at the next clock edge. A fill takes priority over a snoop hit or write completion to the same line in the same cycle.
- R3: A snoop hit (`snp_vld`) alone increments the counter of line `snp_idx` by one.
- R4: A completed local write (`wdone_vld`) alone decrements the counter of line `wdone_idx` by one.
- R5: Counters saturate at the largest positive value (2^(CW-1)-1) and the most negative value (-2^(CW-1)) instead of wrapping.
- R6: A snoop hit and a write completion to the same line in the same cycle, with no fill to that line, leave its counter unchanged.
- R7: Mode 2'b00 (invalidate-only) gives `upd` = 0 for every request.
- R8: Mode 2'b01 (update-only) gives `upd` = 1 for every coherence-generating request.
- R9: Mode 2'b11 (owned rule) gives `upd` = 1 when the line state is Owned (2'b10). It gives `upd` = 0 for Shared (2'b01) or Invalid (2'b00), whatever the counter holds.
- R10: Mode 2'b10 (threshold) gives `upd` = 1 exactly when the line's counter, taken as signed, is greater than or equal to the signed `thr` input. Any `thr` value, including 1, is honoured.
- R11: `upd` is combinational from the registered counters, the mode and the request, and is valid in the same cycle as `wreq_vld`.
- R12: `upd` is 0 whenever `wreq_vld` is low or the request state is 2'b11, which stands for Modified or Exclusive, where no message is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Policy select: 00 invalidate, 01 update, 10 threshold, 11 owned rule |
| thr | input | CW | Signed threshold for mode 10 |
| fill_vld | input | 1 | Line filled from main memory |
| fill_idx | input | IW | Index of filled line |
| snp_vld | input | 1 | Snooped read hit a valid line |
| snp_idx | input | IW | Index of snoop-hit line |
| wdone_vld | input | 1 | Local write completed |
| wdone_idx | input | IW | Index of written line |
| wreq_vld | input | 1 | Local write request needing a decision |
| wreq_idx | input | IW | Index of requested line |
| wreq_st | input | 2 | State of requested line: 00 I, 01 S, 10 O, 11 M/E |
| upd | output | 1 | 1 = broadcast update, 0 = broadcast invalidate |

## Verification
The bench reads each counter back through the threshold mode. It sets the threshold to the expected value and then to one above it, so a counter that is off by one in either direction shows up.

The saturation runs push one line well past both limits. A wrapping counter would flip the sign and turn an update into an invalidate.

Same-cycle snoop-and-write and fill-with-snoop collisions catch a design that lets one event win or ignores fill priority. The owned-rule tests use a line with a high counter, to catch a design that consults the counter in that mode.

// File: rtl/wpol_select.sv
module wpol_select #(
  parameter int LINES = 64,
  parameter int CW    = 4,
  localparam int IW   = $clog2(LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           mode,
  input  logic signed [CW-1:0] thr,
  input  logic                 fill_vld,
  input  logic [IW-1:0]        fill_idx,
  input  logic                 snp_vld,
  input  logic [IW-1:0]        snp_idx,
  input  logic                 wdone_vld,
  input  logic [IW-1:0]        wdone_idx,
  input  logic                 wreq_vld,
  input  logic [IW-1:0]        wreq_idx,
  input  logic [1:0]           wreq_st,
  output logic                 upd
);

  localparam logic signed [CW-1:0] CMAX = {1'b0, {(CW-1){1'b1}}};
  localparam logic signed [CW-1:0] CMIN = {1'b1, {(CW-1){1'b0}}};
  localparam logic [1:0] M_INV = 2'b00, M_UPD = 2'b01, M_THR = 2'b10, M_OWN = 2'b11;
  localparam logic [1:0] ST_O = 2'b10, ST_ME = 2'b11;

  logic signed [CW-1:0] cnt [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    wire fl = fill_vld  && fill_idx  == IW'(i);
    wire up = snp_vld   && snp_idx   == IW'(i);
    wire dn = wdone_vld && wdone_idx == IW'(i);

    always_ff @(posedge clk) begin
      if (!rst_n || fl)                cnt[i] <= '0;
      else if (up && !dn && cnt[i] != CMAX) cnt[i] <= cnt[i] + 1'b1;
      else if (dn && !up && cnt[i] != CMIN) cnt[i] <= cnt[i] - 1'b1;
    end

    a_r2_fill_clears: assert property (@(posedge clk) disable iff (!rst_n)
      fl |=> cnt[i] == '0);
    a_r3_snoop_inc: assert property (@(posedge clk) disable iff (!rst_n)
      (up && !dn && !fl && cnt[i] != CMAX) |=> cnt[i] == $past(cnt[i]) + 1'b1);
    a_r4_write_dec: assert property (@(posedge clk) disable iff (!rst_n)
      (dn && !up && !fl && cnt[i] != CMIN) |=> cnt[i] == $past(cnt[i]) - 1'b1);
    a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (!fl && ((cnt[i] == CMAX && up) || (cnt[i] == CMIN && dn))) |=> $stable(cnt[i]));
    a_r6_collide_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (up && dn && !fl) |=> $stable(cnt[i]));
  end

  logic pick;
  always_comb begin
    unique case (mode)
      M_INV:   pick = 1'b0;
      M_UPD:   pick = 1'b1;
      M_THR:   pick = cnt[wreq_idx] >= thr;
      default: pick = wreq_st == ST_O;
    endcase
  end

  assign upd = wreq_vld && wreq_st != ST_ME && pick;

  a_r7_inv_only: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_INV |-> !upd);
  a_r8_upd_only: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_UPD && wreq_vld && wreq_st != ST_ME) |-> upd);
  a_r9_owned_rule: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_OWN && wreq_vld) |-> upd == (wreq_st == ST_O));
  a_r12_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!wreq_vld || wreq_st == ST_ME) |-> !upd);

endmodule

// File: tb/sim_wpol_select.sv
module sim_wpol_select;
  localparam int PERIOD = 10;
  localparam int LINES = 64, CW = 4, IW = 6;

  logic clk = 0, rst_n = 0;
  logic [1:0] mode = 0;
  logic signed [CW-1:0] thr = 0;
  logic fill_vld = 0, snp_vld = 0, wdone_vld = 0, wreq_vld = 0;
  logic [IW-1:0] fill_idx = 0, snp_idx = 0, wdone_idx = 0, wreq_idx = 0;
  logic [1:0] wreq_st = 0;
  logic upd;
  int checks = 0, errors = 0;

  always #(PERIOD/2) clk = ~clk;

  wpol_select #(.LINES(LINES), .CW(CW)) u0 (
    .clk, .rst_n, .mode, .thr, .fill_vld, .fill_idx, .snp_vld, .snp_idx,
    .wdone_vld, .wdone_idx, .wreq_vld, .wreq_idx, .wreq_st, .upd);

  task automatic chk(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: upd=%0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic snoop(input int idx, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); snp_vld = 1; snp_idx = IW'(idx);
      @(posedge clk); #1 snp_vld = 0;
    end
  endtask

  task automatic wdone(input int idx, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); wdone_vld = 1; wdone_idx = IW'(idx);
      @(posedge clk); #1 wdone_vld = 0;
    end
  endtask

  task automatic fill(input int idx);
    @(negedge clk); fill_vld = 1; fill_idx = IW'(idx);
    @(posedge clk); #1 fill_vld = 0;
  endtask

  task automatic probe(input int idx, input int exp, input string tag);
    @(negedge clk);
    mode = 2'b10; wreq_vld = 1; wreq_idx = IW'(idx); wreq_st = 2'b01;
    thr = CW'(exp); #1 chk(upd, 1'b1, tag);
    if (exp < 7) begin thr = CW'(exp + 1); #1 chk(upd, 1'b0, tag); end
    wreq_vld = 0;
  endtask

  task automatic ask(input logic [1:0] m, input int idx, input logic [1:0] st,
                     input logic exp, input string tag);
    @(negedge clk);
    mode = m; wreq_vld = 1; wreq_idx = IW'(idx); wreq_st = st;
    #1 chk(upd, exp, tag);
    wreq_vld = 0;
  endtask

  task automatic t_reset;
    probe(0, 0, "R1"); probe(5, 0, "R1"); probe(63, 0, "R1");
  endtask

  task automatic t_count;
    snoop(3, 3);  probe(3, 3, "R3");
    wdone(3, 5);  probe(3, -2, "R4");
    fill(3);      probe(3, 0, "R2");
  endtask

  task automatic t_sat;
    snoop(7, 10); probe(7, 7, "R5 max");
    wdone(7, 20); probe(7, -8, "R5 min");
  endtask

  task automatic t_collide;
    snoop(9, 2);
    @(negedge clk); snp_vld = 1; snp_idx = 9; wdone_vld = 1; wdone_idx = 9;
    @(posedge clk); #1 snp_vld = 0; wdone_vld = 0;
    probe(9, 2, "R6 hold");
    @(negedge clk); snp_vld = 1; snp_idx = 9; fill_vld = 1; fill_idx = 9;
    @(posedge clk); #1 snp_vld = 0; fill_vld = 0;
    probe(9, 0, "R2 fill priority");
  endtask

  task automatic t_modes;
    snoop(12, 5);
    for (int s = 0; s < 3; s++) ask(2'b00, 12, 2'(s), 1'b0, "R7");
    for (int s = 0; s < 3; s++) ask(2'b01, 3, 2'(s), 1'b1, "R8");
    ask(2'b11, 7,  2'b10, 1'b1, "R9 owned low cnt");
    ask(2'b11, 12, 2'b01, 1'b0, "R9 shared high cnt");
    ask(2'b11, 12, 2'b00, 1'b0, "R9 invalid high cnt");
    for (int m = 0; m < 4; m++) ask(2'(m), 12, 2'b11, 1'b0, "R12 M/E");
    @(negedge clk); mode = 2'b01; wreq_vld = 0; wreq_st = 2'b01;
    #1 chk(upd, 1'b0, "R12 no request");
  endtask

  task automatic t_thr1;
    snoop(20, 1);
    @(negedge clk); thr = 1; mode = 2'b10; wreq_vld = 1; wreq_st = 2'b10;
    wreq_idx = 20; #1 chk(upd, 1'b1, "R10 cnt1 thr1");
    wreq_idx = 21; #1 chk(upd, 1'b0, "R10 cnt0 thr1");
    wreq_idx = 7;  thr = -8; #1 chk(upd, 1'b1, "R10 signed min");
    wreq_idx = 20; snp_vld = 1; snp_idx = 20;
    #1 chk(upd, 1'b1, "R11 same cycle");
    @(posedge clk); #1 snp_vld = 0; wreq_vld = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset; t_count; t_sat; t_collide; t_modes; t_thr1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule